// File: doc/BRIEF.md
# ATA PIO Single-Sector Sequencer

This block moves one 512-byte sector between a host and an ATA drive in programmed I/O mode with 28-bit LBA addressing. A caller pulses `start` with an operation (read sector, write sector or identify device), a master/slave select bit and an LBA. The block then runs the whole register-level exchange in hardware. It waits for the drive to leave the busy state, programs the address registers, issues the command and waits for the drive to request data. It then moves 256 sixteen-bit words and, after a write, waits for the drive to go idle again. It ends with a one-cycle `done` pulse and an outcome code.

Every drive access follows a fixed shape. Chip select and register address come first. The read or write strobe follows for a set number of cycles, and one more cycle holds the address with the strobe released. Each status wait polls a bounded number of times with an idle gap between polls, so a dead or stuck drive ends in a timeout and never hangs the block. The data bus reaches the pads as a split input, output and output-enable triple.

Top module: `ata_seq`

## Requirements
- R1: Registers are reached with `ataCs0N` low and `ataAddr` as follows: data word 0, sector count 2, LBA bits 7:0 at 3, LBA bits 15:8 at 4, LBA bits 23:16 at 5, device/head 6, command (write) and status (read) 7. `ataCs1N` stays high.
- R2: Before the command, exactly five register writes occur in this order: device/head, LBA 23:16, LBA 15:8, LBA 7:0, sector count with value 1. Each carries its byte on data bits 7:0 with bits 15:8 zero.
- R3: The device/head byte is 0xE0, OR 0x10 when `slave` is 1, OR LBA bits 27:24 in bits 3:0.
- R4: `op` 0, 1 and 2 issue command byte 0x20, 0x30 and 0xEC respectively, written to address 7 after the sector count. `start` with `op`=3 is ignored: no drive access, no `done`, `busy` stays low. `done` is a one-cycle pulse with `errCode` valid in that cycle.
- R5: Status (address 7) is polled until bit 7 is clear before the register loads and again before the command. After the command it is polled until bit 7 is clear and bit 3 is set. After a write data phase it is polled until bit 7 is clear before `done`.
- R6: A wait reads status at most POLL_LIMIT (256) times, with POLL_GAP idle cycles between polls. When the limit is reached, the operation ends with `errCode`=1 and no further access.
- R7: When a wait condition is met and status bit 0 is set, the operation ends with `errCode`=2 and no further access. Success gives `errCode`=0.
- R8: The data phase is exactly 256 accesses to address 0. For a read, each word is given on `rdWord` with a one-cycle `rdWordValid` pulse. For a write, `wrWordTake` pulses once per word after `wrWord` has been consumed, and the consumed value appears on `ataDataOut`.
- R9: Each access holds chip select and address for SETUP_CYC cycles with both strobes high. One strobe is then low for STROBE_CYC cycles, and one more cycle keeps chip select and address with the strobe high. Address is stable throughout.
- R10: `ataDataOe` is high only while `ataDiowN` is low.
- R11: During reset, chip selects and strobes are high, `ataDataOe`, `busy` and `done` are low, and `ataRstN` is low. `ataRstN` goes high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request pulse (accepted when idle) |
| op | input | 2 | 0 read, 1 write, 2 identify, 3 ignored |
| slave | input | 1 | 1 selects the slave drive |
| lba | input | 28 | Logical block address |
| wrWord | input | 16 | Next word to write to the drive |
| wrWordTake | output | 1 | Pulse: `wrWord` consumed, present the next |
| rdWord | output | 16 | Word read from the drive |
| rdWordValid | output | 1 | Pulse: `rdWord` valid |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished pulse |
| errCode | output | 2 | 0 ok, 1 timeout, 2 drive error |
| ataCs0N | output | 1 | Command block chip select, active low |
| ataCs1N | output | 1 | Control block chip select, active low |
| ataAddr | output | 3 | Register address lines |
| ataDiorN | output | 1 | Read strobe, active low |
| ataDiowN | output | 1 | Write strobe, active low |
| ataRstN | output | 1 | Drive reset, active low |
| ataDataIn | input | 16 | Data bus from pads |
| ataDataOut | output | 16 | Data bus to pads |
| ataDataOe | output | 1 | Data bus output enable |

## Verification
The assertions assume that the controller starts a bus access only while the bus is idle. They also assume that the drive keeps `ataDataIn` steady for the whole strobe, so a word captured at the end of the strobe matches the word present when it fell. The bench drive model changes its status and data only when a strobe is released, and the bench changes `wrWord` only after a `wrWordTake` pulse. Stimulus therefore never moves a sampled input in mid-access.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
  localparam int DATA_W = 16;
  localparam int LBA_W = 28;

  typedef enum logic [2:0] {
    SEL_DATA, SEL_SECCNT, SEL_LBALO, SEL_LBAMID, SEL_LBAHI, SEL_DEV, SEL_CMDSTAT
  } regSel_t;

  typedef struct packed {
    logic busGo;
    logic busWr;
    regSel_t sel;
    logic latchCmd;
  } busCmd_t;

  localparam logic [1:0] OP_READ = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_IDENT = 2'd2;
  localparam logic [1:0] OP_NONE = 2'd3;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_TIMEOUT = 2'd1;
  localparam logic [1:0] ERR_DEVICE = 2'd2;

  function automatic logic [2:0] selAddr(regSel_t s);
    case (s)
      SEL_DATA:   return 3'd0;
      SEL_SECCNT: return 3'd2;
      SEL_LBALO:  return 3'd3;
      SEL_LBAMID: return 3'd4;
      SEL_LBAHI:  return 3'd5;
      SEL_DEV:    return 3'd6;
      default:    return 3'd7;
    endcase
  endfunction

  function automatic logic [7:0] opCode(logic [1:0] o);
    case (o)
      OP_WRITE: return 8'h30;
      OP_IDENT: return 8'hEC;
      default:  return 8'h20;
    endcase
  endfunction

  // order in which the address block is programmed
  function automatic regSel_t loadSel(logic [2:0] idx);
    case (idx)
      3'd0:    return SEL_DEV;
      3'd1:    return SEL_LBAHI;
      3'd2:    return SEL_LBAMID;
      3'd3:    return SEL_LBALO;
      default: return SEL_SECCNT;
    endcase
  endfunction
endpackage

// File: rtl/ata_seq_dp.sv
module ata_seq_dp
  import ata_seq_pkg::*;
#(
  parameter int SETUP_CYC = 3,
  parameter int STROBE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCmd_t           cmd,
  input  logic [1:0]        startOp,
  input  logic              startSlave,
  input  logic [LBA_W-1:0]  startLba,
  input  logic [DATA_W-1:0] wrWord,
  input  logic [DATA_W-1:0] ataDataIn,
  output logic              busDone,
  output logic [7:0]        status,
  output logic              wrWordTake,
  output logic [DATA_W-1:0] rdWord,
  output logic              rdWordValid,
  output logic              ataCs0N,
  output logic              ataCs1N,
  output logic [2:0]        ataAddr,
  output logic              ataDiorN,
  output logic              ataDiowN,
  output logic              ataRstN,
  output logic [DATA_W-1:0] ataDataOut,
  output logic              ataDataOe
);
  localparam int MAXC = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_t;

  phase_t            phase;
  logic [CW-1:0]     cnt;
  logic [1:0]        opReg;
  logic              slaveReg;
  logic [LBA_W-1:0]  lbaReg;
  logic [2:0]        addrReg;
  logic              wrReg;
  logic              isDataReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] rdDataReg;
  logic [DATA_W-1:0] wdata;

  always_comb begin
    wdata = '0;
    case (cmd.sel)
      SEL_DATA:   wdata = wrWord;
      SEL_SECCNT: wdata[7:0] = 8'd1;
      SEL_LBALO:  wdata[7:0] = lbaReg[7:0];
      SEL_LBAMID: wdata[7:0] = lbaReg[15:8];
      SEL_LBAHI:  wdata[7:0] = lbaReg[23:16];
      SEL_DEV:    wdata[7:0] = {3'b111, slaveReg, lbaReg[27:24]};
      default:    wdata[7:0] = opCode(opReg);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg <= OP_READ;
      slaveReg <= 1'b0;
      lbaReg <= '0;
    end else if (cmd.latchCmd) begin
      opReg <= startOp;
      slaveReg <= startSlave;
      lbaReg <= startLba;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt <= '0;
      addrReg <= '0;
      wrReg <= 1'b0;
      isDataReg <= 1'b0;
      dataReg <= '0;
      rdDataReg <= '0;
      busDone <= 1'b0;
      wrWordTake <= 1'b0;
      rdWord <= '0;
      rdWordValid <= 1'b0;
      ataRstN <= 1'b0;
    end else begin
      ataRstN <= 1'b1;
      busDone <= 1'b0;
      wrWordTake <= 1'b0;
      rdWordValid <= 1'b0;
      case (phase)
        PH_IDLE: if (cmd.busGo) begin
          addrReg <= selAddr(cmd.sel);
          wrReg <= cmd.busWr;
          isDataReg <= (cmd.sel == SEL_DATA);
          dataReg <= wdata;
          wrWordTake <= cmd.busWr && (cmd.sel == SEL_DATA);
          cnt <= CW'(SETUP_CYC - 1);
          phase <= PH_SETUP;
        end
        PH_SETUP: if (cnt == '0) begin
          cnt <= CW'(STROBE_CYC - 1);
          phase <= PH_STROBE;
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cnt == '0) begin
          if (!wrReg) begin
            rdDataReg <= ataDataIn;
            if (isDataReg) begin
              rdWord <= ataDataIn;
              rdWordValid <= 1'b1;
            end
          end
          phase <= PH_HOLD;
        end else cnt <= cnt - 1'b1;
        default: begin
          busDone <= 1'b1;
          phase <= PH_IDLE;
        end
      endcase
    end
  end

  assign status = rdDataReg[7:0];
  assign ataCs0N = (phase == PH_IDLE);
  assign ataCs1N = 1'b1;
  assign ataAddr = addrReg;
  assign ataDiorN = !((phase == PH_STROBE) && !wrReg);
  assign ataDiowN = !((phase == PH_STROBE) && wrReg);
  assign ataDataOe = (phase == PH_STROBE) && wrReg;
  assign ataDataOut = dataReg;

  logic strobeIdle;
  assign strobeIdle = ataDiorN && ataDiowN;

  // R9
  setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobeIdle) |-> $past(!ataCs0N) && $stable(ataAddr));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeIdle) |-> !ataCs0N && $stable(ataAddr));
  // R9
  strobe_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeIdle && $past(!strobeIdle)) |-> $stable(ataAddr) && $stable(ataDataOut));
  // R9
  go_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.busGo |-> ataCs0N);
  // R8
  rd_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdWordValid |-> $past(!ataDiorN) && ataAddr == 3'd0);
  // R10
  oe_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ataDataOe) |-> $fell(ataDiowN));
endmodule

// File: rtl/ata_seq_ctrl.sv
module ata_seq_ctrl
  import ata_seq_pkg::*;
#(
  parameter int POLL_LIMIT = 256,
  parameter int POLL_GAP = 1000,
  parameter int WORD_COUNT = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] op,
  input  logic       busDone,
  input  logic [7:0] status,
  output busCmd_t    cmd,
  output logic       busy,
  output logic       done,
  output logic [1:0] errCode
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam int WW = $clog2(WORD_COUNT + 1);
  localparam int LOADS = 5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_POLL_GO, ST_POLL_WAIT, ST_GAP, ST_LOAD_GO, ST_LOAD_WAIT,
    ST_CMD_GO, ST_CMD_WAIT, ST_XFER_GO, ST_XFER_WAIT
  } state_t;
  typedef enum logic [1:0] {W_PRELOAD, W_PRECMD, W_DRQ, W_POSTWR} wait_t;

  state_t        st;
  wait_t         waitKind;
  logic [PW-1:0] pollCnt;
  logic [GW-1:0] gapCnt;
  logic [2:0]    loadIdx;
  logic [WW-1:0] wordCnt;
  logic          isWrite;
  logic          condMet;

  assign condMet = !status[7] && ((waitKind != W_DRQ) || status[3]);
  assign busy = (st != ST_IDLE);

  always_comb begin
    cmd = '0;
    case (st)
      ST_IDLE:    cmd.latchCmd = start && (op != OP_NONE);
      ST_POLL_GO: begin cmd.busGo = 1'b1; cmd.sel = SEL_CMDSTAT; end
      ST_LOAD_GO: begin cmd.busGo = 1'b1; cmd.busWr = 1'b1; cmd.sel = loadSel(loadIdx); end
      ST_CMD_GO:  begin cmd.busGo = 1'b1; cmd.busWr = 1'b1; cmd.sel = SEL_CMDSTAT; end
      ST_XFER_GO: begin cmd.busGo = 1'b1; cmd.busWr = isWrite; cmd.sel = SEL_DATA; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= ST_IDLE;
      waitKind <= W_PRELOAD;
      pollCnt <= '0;
      gapCnt <= '0;
      loadIdx <= '0;
      wordCnt <= '0;
      isWrite <= 1'b0;
      done <= 1'b0;
      errCode <= ERR_NONE;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start && op != OP_NONE) begin
          isWrite <= (op == OP_WRITE);
          waitKind <= W_PRELOAD;
          pollCnt <= '0;
          st <= ST_POLL_GO;
        end
        ST_POLL_GO: st <= ST_POLL_WAIT;
        ST_POLL_WAIT: if (busDone) begin
          if (condMet) begin
            if (status[0]) begin
              errCode <= ERR_DEVICE; done <= 1'b1; st <= ST_IDLE;
            end else begin
              case (waitKind)
                W_PRELOAD: begin loadIdx <= '0; st <= ST_LOAD_GO; end
                W_PRECMD:  st <= ST_CMD_GO;
                W_DRQ:     begin wordCnt <= '0; st <= ST_XFER_GO; end
                default:   begin errCode <= ERR_NONE; done <= 1'b1; st <= ST_IDLE; end
              endcase
            end
          end else if (pollCnt == PW'(POLL_LIMIT - 1)) begin
            errCode <= ERR_TIMEOUT; done <= 1'b1; st <= ST_IDLE;
          end else begin
            pollCnt <= pollCnt + 1'b1;
            gapCnt <= '0;
            st <= ST_GAP;
          end
        end
        ST_GAP: if (gapCnt == GW'(POLL_GAP - 1)) st <= ST_POLL_GO;
                else gapCnt <= gapCnt + 1'b1;
        ST_LOAD_GO: st <= ST_LOAD_WAIT;
        ST_LOAD_WAIT: if (busDone) begin
          if (loadIdx == 3'(LOADS - 1)) begin
            waitKind <= W_PRECMD; pollCnt <= '0; st <= ST_POLL_GO;
          end else begin
            loadIdx <= loadIdx + 1'b1; st <= ST_LOAD_GO;
          end
        end
        ST_CMD_GO: st <= ST_CMD_WAIT;
        ST_CMD_WAIT: if (busDone) begin
          waitKind <= W_DRQ; pollCnt <= '0; st <= ST_POLL_GO;
        end
        ST_XFER_GO: st <= ST_XFER_WAIT;
        ST_XFER_WAIT: if (busDone) begin
          if (wordCnt == WW'(WORD_COUNT - 1)) begin
            if (isWrite) begin
              waitKind <= W_POSTWR; pollCnt <= '0; st <= ST_POLL_GO;
            end else begin
              errCode <= ERR_NONE; done <= 1'b1; st <= ST_IDLE;
            end
          end else begin
            wordCnt <= wordCnt + 1'b1; st <= ST_XFER_GO;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);
  // R7
  err_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && errCode == ERR_DEVICE) |-> status[0]);
  // R6
  timeout_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && errCode == ERR_TIMEOUT) |-> (status[7] || !status[3]));
  // R8
  xfer_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.busGo && cmd.sel == SEL_DATA) |-> wordCnt < WW'(WORD_COUNT));
endmodule

// File: rtl/ata_seq.sv
module ata_seq
  import ata_seq_pkg::*;
#(
  parameter int SETUP_CYC = 3,
  parameter int STROBE_CYC = 4,
  parameter int POLL_GAP = 1000,
  parameter int POLL_LIMIT = 256,
  parameter int WORD_COUNT = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic        slave,
  input  logic [27:0] lba,
  input  logic [15:0] wrWord,
  output logic        wrWordTake,
  output logic [15:0] rdWord,
  output logic        rdWordValid,
  output logic        busy,
  output logic        done,
  output logic [1:0]  errCode,
  output logic        ataCs0N,
  output logic        ataCs1N,
  output logic [2:0]  ataAddr,
  output logic        ataDiorN,
  output logic        ataDiowN,
  output logic        ataRstN,
  input  logic [15:0] ataDataIn,
  output logic [15:0] ataDataOut,
  output logic        ataDataOe
);
  busCmd_t    cmd;
  logic       busDone;
  logic [7:0] status;

  ata_seq_ctrl #(.POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP), .WORD_COUNT(WORD_COUNT)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .busDone(busDone), .status(status),
    .cmd(cmd), .busy(busy), .done(done), .errCode(errCode)
  );

  ata_seq_dp #(.SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .startOp(op), .startSlave(slave), .startLba(lba),
    .wrWord(wrWord), .ataDataIn(ataDataIn), .busDone(busDone), .status(status),
    .wrWordTake(wrWordTake), .rdWord(rdWord), .rdWordValid(rdWordValid),
    .ataCs0N(ataCs0N), .ataCs1N(ataCs1N), .ataAddr(ataAddr), .ataDiorN(ataDiorN),
    .ataDiowN(ataDiowN), .ataRstN(ataRstN), .ataDataOut(ataDataOut), .ataDataOe(ataDataOe)
  );
endmodule

// File: tb/ata_seq_tb_top.sv
module ata_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_SETUP = 2;
  localparam int TB_STROBE = 3;
  localparam int TB_GAP = 4;
  localparam int POLL_PERIOD = TB_SETUP + TB_STROBE + TB_GAP + 3;

  logic clk = 0;
  logic rstN = 0;
  logic start = 0;
  logic [1:0] op = 0;
  logic slave = 0;
  logic [27:0] lba = 0;
  logic [15:0] wrWord;
  logic wrWordTake, rdWordValid, busy, done;
  logic [15:0] rdWord, ataDataOut, ataDataIn;
  logic [1:0] errCode;
  logic ataCs0N, ataCs1N, ataDiorN, ataDiowN, ataRstN, ataDataOe;
  logic [2:0] ataAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_seq #(.SETUP_CYC(TB_SETUP), .STROBE_CYC(TB_STROBE), .POLL_GAP(TB_GAP)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .slave(slave), .lba(lba),
    .wrWord(wrWord), .wrWordTake(wrWordTake), .rdWord(rdWord), .rdWordValid(rdWordValid),
    .busy(busy), .done(done), .errCode(errCode), .ataCs0N(ataCs0N), .ataCs1N(ataCs1N),
    .ataAddr(ataAddr), .ataDiorN(ataDiorN), .ataDiowN(ataDiowN), .ataRstN(ataRstN),
    .ataDataIn(ataDataIn), .ataDataOut(ataDataOut), .ataDataOe(ataDataOe)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  // drive model state
  int busyLeft = 0, cmdBusy = 0, postBusy = 0, wordIdx = 0;
  bit stuck = 0, errInject = 0, dataPhase = 0;
  int wrLog[$];
  int statusReads = 0, rdCount = 0, rdBad = 0, takeCount = 0, doneCount = 0;
  int protoErr = 0, gapBad = 0, cyc = 0, lastStatFall = -1;
  int setupRun = 0, strobeRun = 0;
  logic prevDior = 1, prevDiow = 1;
  logic [2:0] prevAddr = 0;
  logic [15:0] prevData = 0;
  logic [7:0] statusByte;

  function automatic logic [15:0] readPat(int i);
    return 16'(16'h5A00 + i * 37);
  endfunction
  function automatic logic [15:0] writePat(int i);
    return 16'(16'hC000 ^ (i * 7));
  endfunction

  always_comb begin
    if (stuck || busyLeft > 0) statusByte = 8'h80;
    else if (dataPhase && errInject) statusByte = 8'h49;
    else if (dataPhase) statusByte = 8'h48;
    else statusByte = 8'h40;
  end

  always_comb begin
    if (ataAddr == 3'd7) ataDataIn = {8'h00, statusByte};
    else if (ataAddr == 3'd0) ataDataIn = readPat(wordIdx);
    else ataDataIn = 16'h0000;
  end

  // per-clock reference: protocol timing and drive behaviour
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (!ataDiorN && !ataDiowN) protoErr++;
      if ((!ataDiorN || !ataDiowN) && ataCs0N) protoErr++;
      if (ataDataOe && ataDiowN) protoErr++;
      if (!ataCs1N) protoErr++;
      if (done) doneCount++;
      if (!ataCs0N && ataDiorN && ataDiowN) begin
        if (!prevDior || !prevDiow) begin
          if (strobeRun != TB_STROBE) protoErr++;
          if (ataAddr != prevAddr) protoErr++;
        end else setupRun++;
      end
      if (ataCs0N) setupRun = 0;
      if ((!ataDiorN || !ataDiowN) && prevDior && prevDiow) begin
        if (setupRun != TB_SETUP) protoErr++;
        setupRun = 0;
        strobeRun = 0;
        if (!ataDiorN && ataAddr == 3'd7) begin
          if (stuck && lastStatFall >= 0 && (cyc - lastStatFall) != POLL_PERIOD) gapBad++;
          lastStatFall = cyc;
        end
      end
      if (!ataDiorN || !ataDiowN) begin
        strobeRun++;
        if ((!prevDior || !prevDiow) && (ataAddr != prevAddr || ataDataOut != prevData)) protoErr++;
      end
      if (!prevDior && ataDiorN) begin
        if (prevAddr == 3'd7) begin
          statusReads++;
          if (busyLeft > 0) busyLeft--;
        end else if (prevAddr == 3'd0) begin
          wordIdx++;
          if (wordIdx == 256) dataPhase = 0;
        end
      end
      if (!prevDiow && ataDiowN) begin
        wrLog.push_back(int'(prevAddr) * 65536 + int'(prevData));
        if (prevAddr == 3'd7) begin
          busyLeft = cmdBusy; dataPhase = 1; wordIdx = 0;
        end else if (prevAddr == 3'd0) begin
          wordIdx++;
          if (wordIdx == 256) begin dataPhase = 0; busyLeft = postBusy; end
        end
      end
      if (rdWordValid) begin
        if (rdWord != readPat(rdCount)) rdBad++;
        rdCount++;
      end
      if (wrWordTake) begin
        takeCount++;
        wrWord = writePat(takeCount);
      end
    end
    prevDior = ataDiorN;
    prevDiow = ataDiowN;
    prevAddr = ataAddr;
    prevData = ataDataOut;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [1:0] gotErr;
  bit seenDone;
  int protoBase;

  task automatic runOp(input logic [1:0] o, input logic s, input logic [27:0] l,
                       input int pre, input int cb, input int pb, input bit stk, input bit ei);
    wrLog.delete();
    statusReads = 0; rdCount = 0; rdBad = 0; takeCount = 0; gapBad = 0; lastStatFall = -1;
    wrWord = writePat(0);
    busyLeft = pre; cmdBusy = cb; postBusy = pb; stuck = stk; errInject = ei;
    dataPhase = 0; wordIdx = 0; protoBase = protoErr; doneCount = 0;
    @(negedge clk);
    op = o; slave = s; lba = l; start = 1;
    @(negedge clk);
    start = 0;
    seenDone = 0;
    gotErr = 2'd3;
    for (int k = 0; k < 60000 && !seenDone; k++) begin
      @(negedge clk);
      if (done) begin seenDone = 1; gotErr = errCode; end
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic checkLoad(input logic s, input logic [27:0] l, input logic [7:0] code, input string tag);
    int exp[6];
    bit ok;
    exp[0] = 6 * 65536 + int'({3'b111, s, l[27:24]});
    exp[1] = 5 * 65536 + int'(l[23:16]);
    exp[2] = 4 * 65536 + int'(l[15:8]);
    exp[3] = 3 * 65536 + int'(l[7:0]);
    exp[4] = 2 * 65536 + 1;
    exp[5] = 7 * 65536 + int'(code);
    ok = wrLog.size() >= 6;
    for (int i = 0; i < 6; i++) begin
      if (ok && wrLog[i] != exp[i]) begin
        $display("FAIL %s write %0d actual=%0h expected=%0h", tag, i, wrLog[i], exp[i]);
        ok = 0;
        failures++;
        checks++;
        return;
      end
    end
    check(ok, tag, wrLog.size(), 6);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    wrWord = writePat(0);
    repeat (3) @(negedge clk);
    // R11 reset state
    check(ataCs0N && ataCs1N && ataDiorN && ataDiowN && !ataDataOe, "R11 pins", 0, 0);
    check(!busy && !done, "R11 busy/done", {busy, done}, 0);
    check(ataRstN == 1'b0, "R11 drive reset", ataRstN, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    check(ataRstN == 1'b1, "R11 drive reset release", ataRstN, 1);

    // R1 R2 R3 R4 R5 R8: read, master
    runOp(2'd0, 1'b0, 28'h0ABCDEF, 3, 5, 0, 0, 0);
    check(seenDone && gotErr == 2'd0, "R7 read ok code", gotErr, 0);
    checkLoad(1'b0, 28'h0ABCDEF, 8'h20, "R2 read load order");
    check(wrLog.size() == 6, "R1 read no extra writes", wrLog.size(), 6);
    check(rdCount == 256 && rdBad == 0, "R8 read words", rdCount * 1000 + rdBad, 256000);
    check(statusReads == 11, "R5 read polls", statusReads, 11);
    check(protoErr == protoBase, "R9 read timing", protoErr - protoBase, 0);
    check(doneCount == 1, "R4 single done", doneCount, 1);

    // R3 R4: identify, slave, high nibble set
    runOp(2'd2, 1'b1, 28'hF123456, 0, 2, 0, 0, 0);
    check(seenDone && gotErr == 2'd0, "R7 ident ok code", gotErr, 0);
    checkLoad(1'b1, 28'hF123456, 8'hEC, "R3 ident devhead");
    check(rdCount == 256 && rdBad == 0, "R8 ident words", rdCount * 1000 + rdBad, 256000);

    // R4 R5 R8 R10: write, slave, post-write busy
    runOp(2'd1, 1'b1, 28'h5000001, 0, 0, 7, 0, 0);
    check(seenDone && gotErr == 2'd0, "R5 write ok code", gotErr, 0);
    checkLoad(1'b1, 28'h5000001, 8'h30, "R4 write command");
    check(wrLog.size() == 262, "R8 write count", wrLog.size(), 262);
    begin
      int bad = 0;
      for (int i = 0; i < 256 && 6 + i < wrLog.size(); i++)
        if (wrLog[6 + i] != int'(writePat(i))) bad++;
      check(bad == 0, "R8 write data", bad, 0);
    end
    check(takeCount == 256, "R8 take pulses", takeCount, 256);
    check(statusReads == 11, "R5 post-write wait", statusReads, 11);
    check(protoErr == protoBase, "R10 write timing", protoErr - protoBase, 0);

    // R6: stuck busy
    runOp(2'd0, 1'b0, 28'h0000010, 0, 0, 0, 1, 0);
    check(seenDone && gotErr == 2'd1, "R6 timeout code", gotErr, 1);
    check(statusReads == 256, "R6 poll count", statusReads, 256);
    check(wrLog.size() == 0, "R6 no access after timeout", wrLog.size(), 0);
    check(gapBad == 0, "R6 poll gap", gapBad, 0);

    // R7: drive error bit after command
    runOp(2'd0, 1'b0, 28'h0000020, 0, 1, 0, 0, 1);
    check(seenDone && gotErr == 2'd2, "R7 error code", gotErr, 2);
    check(wrLog.size() == 6 && rdCount == 0, "R7 stops", wrLog.size() * 1000 + rdCount, 6000);

    // R4: op 3 ignored
    wrLog.delete(); statusReads = 0; doneCount = 0;
    @(negedge clk); op = 2'd3; start = 1;
    @(negedge clk); start = 0;
    begin
      int busySeen = 0;
      for (int k = 0; k < 50; k++) begin
        @(negedge clk);
        if (busy || !ataCs0N) busySeen++;
      end
      check(busySeen == 0 && doneCount == 0 && wrLog.size() == 0 && statusReads == 0,
            "R4 op3 ignored", busySeen + doneCount, 0);
    end

    // R4: normal op still works after ignored request
    runOp(2'd0, 1'b0, 28'h1234567, 0, 0, 0, 0, 0);
    check(seenDone && gotErr == 2'd0 && rdCount == 256, "R4 read after op3", gotErr, 0);
    checkLoad(1'b0, 28'h1234567, 8'h20, "R1 reload");

    finishRun();
  end
endmodule